// File: doc/BRIEF.md
# Conditional relative jump unit

This block resolves the control-flow outcome of a conditional relative jump for a 16-bit processor pipeline. Each cycle it may be given one instruction word, the current status register and the program counter already advanced past that word. It decides whether the word belongs to the jump format. For a jump, it tests the selected condition against the carry, zero, negative and overflow flags. It then returns the program counter for the next instruction together with a taken indication.

The jump format is recognised by a fixed three-bit pattern at the top of the word. A three-bit condition selector sits above a ten-bit signed word displacement. The displacement is doubled into a byte distance and added to the incremented program counter. The sum wraps modulo 2^16. The decision logic is purely combinational. One register stage holds the result, and a valid bit marks the cycle that carries a fresh result, so that a pipeline stage can consume the result one clock after issue. The status register is only read.

Top module: `jmp_unit`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, out_valid, out_is_jump and out_taken are 0 and out_next_pc is 0.
- R2: out_valid is high exactly in the cycle after a clock edge at which in_valid was high. The other outputs then reflect the inputs sampled at that edge. After an edge with in_valid low, out_is_jump, out_taken and out_next_pc keep their previous values.
- R3: out_is_jump is 1 exactly when instr[15:13] equals 3'b001. For any other word, out_taken is 0.
- R4: The condition selector is instr[12:10]. Code 0 is taken when Z (status bit 1) is 0. Code 1 is taken when Z is 1. Code 2 is taken when C (status bit 0) is 0. Code 3 is taken when C is 1. Code 4 is taken when N (status bit 2) is 1. Code 7 is always taken.
- R5: Code 5 is taken when N (status bit 2) equals V (status bit 8). Code 6 is taken when they differ.
- R6: For a taken jump, out_next_pc = pc_inc + 2 * sext(instr[9:0]) modulo 2^16. Bit 9 is the sign bit, so the word displacement ranges from -512 to +511.
- R7: When the jump is not taken, or the word is not a jump, out_next_pc equals pc_inc.
- R8: Status bits other than 0, 1, 2 and 8 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inputs carry an instruction to resolve this cycle |
| instr | input | 16 | Instruction word |
| status | input | 16 | Current status register (read only) |
| pc_inc | input | 16 | Program counter already advanced past instr |
| out_valid | output | 1 | Registered result is fresh this cycle |
| out_is_jump | output | 1 | Word was in jump format |
| out_taken | output | 1 | Jump condition was met |
| out_next_pc | output | 16 | Program counter for the next instruction |

## Verification
The bench builds the unit with its default parameters: a 16-bit word, a 10-bit displacement, and flags at bits 0, 1, 2 and 8. With this geometry the extreme displacements of +511 and -512 words can be reached directly. So can a target that wraps past 0xFFFF or below 0x0000. The bench also walks every condition code with its flags both set and cleared, and it sets every unrelated status bit to show that those bits are ignored. Pseudo-random words, flags and gaps in in_valid then stress the hold behaviour and the format decode against a behavioural model.

// File: rtl/jmp_pkg.sv
package jmp_pkg;
  localparam int CODE_W = 3;
  localparam int CODE_N = 1 << CODE_W;

  typedef enum logic [CODE_W-1:0] {
    CC_ZCLR = 3'd0,
    CC_ZSET = 3'd1,
    CC_CCLR = 3'd2,
    CC_CSET = 3'd3,
    CC_NSET = 3'd4,
    CC_GE   = 3'd5,
    CC_LT   = 3'd6,
    CC_AL   = 3'd7
  } cond_e;
endpackage

// File: rtl/jmp_decode.sv
module jmp_decode
  import jmp_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int OFS_W   = 10,
  parameter int FMT_W   = 3,
  parameter int FMT_VAL = 1
) (
  input  logic [WORD_W-1:0] instr,
  output logic              is_jump,
  output cond_e             code,
  output logic [WORD_W-1:0] disp
);
  localparam int EXT_W = WORD_W - OFS_W - 1;

  function automatic logic [WORD_W-1:0] byte_disp(input logic [OFS_W-1:0] w);
    return {{EXT_W{w[OFS_W-1]}}, w, 1'b0};
  endfunction

  assign is_jump = (instr[WORD_W-1 -: FMT_W] == FMT_VAL[FMT_W-1:0]);
  assign code    = cond_e'(instr[OFS_W +: CODE_W]);
  assign disp    = byte_disp(instr[OFS_W-1:0]);
endmodule

// File: rtl/jmp_cond_eval.sv
module jmp_cond_eval
  import jmp_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int C_BIT  = 0,
  parameter int Z_BIT  = 1,
  parameter int N_BIT  = 2,
  parameter int V_BIT  = 8
) (
  input  logic [WORD_W-1:0] status,
  input  cond_e             code,
  output logic              pass
);
  logic fc, fz, fn, fv;
  logic [CODE_N-1:0] hit;

  assign fc = status[C_BIT];
  assign fz = status[Z_BIT];
  assign fn = status[N_BIT];
  assign fv = status[V_BIT];

  for (genvar i = 0; i < CODE_N; i++) begin : g_cc
    if (i == int'(CC_ZCLR))      begin : g_zc assign hit[i] = ~fz;       end
    else if (i == int'(CC_ZSET)) begin : g_zs assign hit[i] = fz;        end
    else if (i == int'(CC_CCLR)) begin : g_cc0 assign hit[i] = ~fc;      end
    else if (i == int'(CC_CSET)) begin : g_cs assign hit[i] = fc;        end
    else if (i == int'(CC_NSET)) begin : g_ns assign hit[i] = fn;        end
    else if (i == int'(CC_GE))   begin : g_ge assign hit[i] = ~(fn ^ fv); end
    else if (i == int'(CC_LT))   begin : g_lt assign hit[i] = fn ^ fv;   end
    else                         begin : g_al assign hit[i] = 1'b1;      end
  end

  assign pass = hit[code];
endmodule

// File: rtl/jmp_target.sv
module jmp_target #(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] pc_inc,
  input  logic [WORD_W-1:0] disp,
  input  logic              take,
  output logic [WORD_W-1:0] next_pc
);
  function automatic logic [WORD_W-1:0] wrap_add(input logic [WORD_W-1:0] a,
                                                 input logic [WORD_W-1:0] b);
    return a + b;
  endfunction

  assign next_pc = take ? wrap_add(pc_inc, disp) : pc_inc;
endmodule

// File: rtl/jmp_unit.sv
module jmp_unit
  import jmp_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int OFS_W   = 10,
  parameter int FMT_W   = 3,
  parameter int FMT_VAL = 1,
  parameter int C_BIT   = 0,
  parameter int Z_BIT   = 1,
  parameter int N_BIT   = 2,
  parameter int V_BIT   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] instr,
  input  logic [WORD_W-1:0] status,
  input  logic [WORD_W-1:0] pc_inc,
  output logic              out_valid,
  output logic              out_is_jump,
  output logic              out_taken,
  output logic [WORD_W-1:0] out_next_pc
);
  // named internal events
  logic              jump_hit;
  cond_e             cond_code;
  logic [WORD_W-1:0] disp;
  logic              cond_pass;
  logic              take_now;
  logic [WORD_W-1:0] target_pc;
  logic              status_unused;

  assign status_unused = ^status;

  jmp_decode #(.WORD_W(WORD_W), .OFS_W(OFS_W), .FMT_W(FMT_W), .FMT_VAL(FMT_VAL)) dec_i (
    .instr   (instr),
    .is_jump (jump_hit),
    .code    (cond_code),
    .disp    (disp)
  );

  jmp_cond_eval #(.WORD_W(WORD_W), .C_BIT(C_BIT), .Z_BIT(Z_BIT),
                  .N_BIT(N_BIT), .V_BIT(V_BIT)) cond_i (
    .status (status),
    .code   (cond_code),
    .pass   (cond_pass)
  );

  assign take_now = jump_hit & cond_pass;

  jmp_target #(.WORD_W(WORD_W)) tgt_i (
    .pc_inc  (pc_inc),
    .disp    (disp),
    .take    (take_now),
    .next_pc (target_pc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_is_jump <= 1'b0;
      out_taken   <= 1'b0;
      out_next_pc <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_is_jump <= jump_hit;
        out_taken   <= take_now;
        out_next_pc <= target_pc;
      end
    end
  end

  // R2: a fresh result follows every accepted input
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R2: idle cycles leave the result untouched
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_next_pc) && $stable(out_taken) && !out_valid));
  // R3: a word outside the jump format never branches
  a_r3_nonjump_untaken: assert property (@(posedge clk) disable iff (!rst_n)
    !jump_hit |-> !take_now);
  // R6: a branch moves the PC by an even distance
  a_r6_even_delta: assert property (@(posedge clk) disable iff (!rst_n)
    take_now |-> ((target_pc[0] ^ pc_inc[0]) == 1'b0));
  // R7: untaken results carry the incremented PC
  a_r7_untaken_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !take_now) |=> (out_next_pc == $past(pc_inc)));
  // R4: the unconditional code always branches in jump format
  a_r4_always: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_hit && cond_code == CC_AL) |-> take_now);
  // R5: the two signed codes are complementary for the same flags
  a_r5_signed_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_hit && (cond_code == CC_GE || cond_code == CC_LT)) |->
      (take_now == ((cond_code == CC_GE) ~^ (status[N_BIT] ~^ status[V_BIT]))));
endmodule

// File: tb/jmp_unit_tb_top.sv
`timescale 1ns/1ps
module jmp_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] instr = 16'h0;
  logic [15:0] status = 16'h0;
  logic [15:0] pc_inc = 16'h0;
  logic        out_valid, out_is_jump, out_taken;
  logic [15:0] out_next_pc;

  int checks = 0;
  int failures = 0;
  bit started = 0;
  bit done = 0;
  string tag = "random";

  // behavioural model state
  bit m_valid = 0, m_jump = 0, m_taken = 0;
  int m_pc = 0;

  always #10 clk = ~clk;

  jmp_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .status(status), .pc_inc(pc_inc), .out_valid(out_valid),
    .out_is_jump(out_is_jump), .out_taken(out_taken), .out_next_pc(out_next_pc)
  );

  function automatic bit ref_taken(int w, int sr);
    int code = (w / 1024) % 8;
    bit c = (sr % 2) == 1;
    bit z = ((sr / 2) % 2) == 1;
    bit n = ((sr / 4) % 2) == 1;
    bit v = ((sr / 256) % 2) == 1;
    if ((w / 8192) != 1) return 0;
    case (code)
      0: return !z;
      1: return z;
      2: return !c;
      3: return c;
      4: return n;
      5: return n == v;
      6: return n != v;
      default: return 1;
    endcase
  endfunction

  function automatic int ref_pc(int w, int sr, int pc);
    int ofs = w % 1024;
    if (ofs >= 512) ofs = ofs - 1024;
    if (!ref_taken(w, sr)) return pc;
    return (pc + 2 * ofs + 65536 * 4) % 65536;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_jump = 0; m_taken = 0; m_pc = 0;
    end else begin
      m_valid = in_valid;
      if (in_valid) begin
        m_jump  = (int'(instr) / 8192) == 1;
        m_taken = ref_taken(int'(instr), int'(status));
        m_pc    = ref_pc(int'(instr), int'(status), int'(pc_inc));
      end
    end
    started = 1;
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s [%s] act=%0h exp=%0h", req, what, tag, act, exp);
    end
  endtask

  // compared on every clock, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R2", "out_valid", int'(out_valid), int'(m_valid));
      chk("R3", "out_is_jump", int'(out_is_jump), int'(m_jump));
      chk(m_jump ? "R4/R5" : "R3", "out_taken", int'(out_taken), int'(m_taken));
      chk(m_taken ? "R6" : "R7", "out_next_pc", int'(out_next_pc), m_pc);
    end
  end

  task automatic issue(string t, logic [15:0] w, logic [15:0] sr, logic [15:0] pc);
    @(negedge clk);
    tag = t; in_valid = 1'b1; instr = w; status = sr; pc_inc = pc;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic expect_now(string req, logic taken, logic [15:0] pc);
    #1;
    chk(req, "directed taken", int'(out_taken), int'(taken));
    chk(req, "directed pc", int'(out_next_pc), int'(pc));
  endtask

  initial begin
    #4000000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    repeat (3) @(negedge clk);
    tag = "reset";
    chk("R1", "reset valid", int'(out_valid), 0);
    chk("R1", "reset taken", int'(out_taken), 0);
    chk("R1", "reset is_jump", int'(out_is_jump), 0);
    chk("R1", "reset pc", int'(out_next_pc), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "post-reset valid", int'(out_valid), 0);
    chk("R1", "post-reset pc", int'(out_next_pc), 0);

    // R4: each simple code, flag set and clear (offset +3 words)
    for (int code = 0; code < 8; code++) begin
      for (int f = 0; f < 2; f++) begin
        logic [15:0] w = 16'h2000 | 16'(code << 10) | 16'h0003;
        logic [15:0] sr = f ? 16'h0107 : 16'h0000;
        issue("R4 sweep", w, sr, 16'h1000);
      end
    end
    // R4 directed: JNE with Z clear branches, JEQ with Z clear falls through
    issue("R4 jne", 16'h2005, 16'h0000, 16'h0200); expect_now("R4", 1'b1, 16'h020A);
    issue("R4 jeq", 16'h2405, 16'h0000, 16'h0200); expect_now("R4", 1'b0, 16'h0200);
    issue("R4 jmp", 16'h3C01, 16'hFFFF, 16'h0010); expect_now("R4", 1'b1, 16'h0012);

    // R5: signed codes across all N/V combinations
    issue("R5 ge nv00", 16'h3401, 16'h0000, 16'h0100); expect_now("R5", 1'b1, 16'h0102);
    issue("R5 ge nv10", 16'h3401, 16'h0004, 16'h0100); expect_now("R5", 1'b0, 16'h0100);
    issue("R5 ge nv01", 16'h3401, 16'h0100, 16'h0100); expect_now("R5", 1'b0, 16'h0100);
    issue("R5 ge nv11", 16'h3401, 16'h0104, 16'h0100); expect_now("R5", 1'b1, 16'h0102);
    issue("R5 lt nv10", 16'h3801, 16'h0004, 16'h0100); expect_now("R5", 1'b1, 16'h0102);
    issue("R5 lt nv01", 16'h3801, 16'h0100, 16'h0100); expect_now("R5", 1'b1, 16'h0102);
    issue("R5 lt nv11", 16'h3801, 16'h0104, 16'h0100); expect_now("R5", 1'b0, 16'h0100);

    // R6: displacement extremes and wrap-around
    issue("R6 max", 16'h3DFF, 16'h0000, 16'h4000); expect_now("R6", 1'b1, 16'h43FE);
    issue("R6 min", 16'h3E00, 16'h0000, 16'h4000); expect_now("R6", 1'b1, 16'h3C00);
    issue("R6 wrap up", 16'h3C01, 16'h0000, 16'hFFFE); expect_now("R6", 1'b1, 16'h0000);
    issue("R6 wrap down", 16'h3FFF, 16'h0000, 16'h0000); expect_now("R6", 1'b1, 16'hFFFE);
    issue("R6 zero", 16'h3C00, 16'h0000, 16'h1234); expect_now("R6", 1'b1, 16'h1234);

    // R3/R7: non-jump words keep pc_inc even with an always-code pattern below
    issue("R3 mov", 16'h4130, 16'h0000, 16'h0800); expect_now("R3", 1'b0, 16'h0800);
    issue("R3 low", 16'h1C00, 16'h0000, 16'h0800); expect_now("R3", 1'b0, 16'h0800);
    issue("R3 high", 16'hFFFF, 16'h0000, 16'h0800); expect_now("R3", 1'b0, 16'h0800);
    issue("R7 untaken", 16'h2C10, 16'h0000, 16'h0ABC); expect_now("R7", 1'b0, 16'h0ABC);

    // R8: every unrelated status bit set, decision flags clear
    issue("R8 jne", 16'h2004, 16'hFEF8, 16'h0300); expect_now("R8", 1'b1, 16'h0308);
    issue("R8 jeq", 16'h2404, 16'hFEF8, 16'h0300); expect_now("R8", 1'b0, 16'h0300);
    issue("R8 jc", 16'h2C04, 16'hFEF8, 16'h0300); expect_now("R8", 1'b0, 16'h0300);
    issue("R8 jge", 16'h3404, 16'hFEF8, 16'h0300); expect_now("R8", 1'b1, 16'h0308);

    // R2: idle cycles with changing inputs hold the result
    issue("R2 base", 16'h3C02, 16'h0000, 16'h0500);
    @(negedge clk);
    instr = 16'h4000; pc_inc = 16'h9999; status = 16'hFFFF;
    @(negedge clk);
    #1;
    chk("R2", "hold pc", int'(out_next_pc), 16'h0504);
    chk("R2", "hold taken", int'(out_taken), 1);
    chk("R2", "idle valid", int'(out_valid), 0);

    // random stream with in_valid gaps
    tag = "random";
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      in_valid = lf[0] | lf[5];
      instr = (lf[3] ? {3'b001, lf[12:0]} : lf ^ 16'h5A5A);
      status = {lf[7:0], lf[15:8]};
      pc_inc = lf * 16'd3;
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule